// File: doc/BRIEF.md
# Charge Pump Fault Supervisor

This block guards a motor driver against two charge pump problems, each reported as a synchronous one-bit flag: the pump voltage is too low, or the pump output is shorted. It drives three controls: an active-low fault line, the driver enable and the charge pump enable. It also keeps one sticky status bit per condition for software to read and clear.

The two conditions recover in different ways. An undervoltage only follows its flag. The driver is held off for as long as the flag stays high and resumes on the cycle after it drops, with no timer. A short turns off both the pump and the driver for a fixed retry interval of `RETRY_CYCLES` clocks, which is five seconds at the system clock. The block then re-enables both. If the short is still reported in the first enabled cycle, a new full interval starts at once. A lasting short therefore gives a steady off/on retry rhythm.

Software clears a status bit by a write strobe whose data bit for that condition is 0. A data bit of 1 leaves that status bit as it is. The undervoltage status bit comes out of reset set.

Top module: `cp_fault_supervisor`

## Requirements
- R1: A high `uv_flag_i` sampled on a clock edge makes `drv_en_o` 0 and `fault_n_o` 0 from that edge on. `cp_en_o` is not affected by this condition.
- R2: When `uv_flag_i` is sampled low, the undervoltage condition is gone after that edge. If no short hold is active, `drv_en_o` and `fault_n_o` return to 1 with no delay interval.
- R3: After reset, `uv_sts_o` reads 1.
- R4: `uv_sts_o` becomes 1 on the edge after `uv_flag_i` is high. It stays 1 until an edge with `clr_we_i`=1 and `clr_data_i[0]`=0. A write with `clr_data_i[0]`=1 leaves it unchanged.
- R5: A high `sc_flag_i` sampled while `cp_en_o` is 1 makes `cp_en_o`, `drv_en_o` and `fault_n_o` 0 for exactly `RETRY_CYCLES` consecutive cycles.
- R6: Short flags sampled while a hold is running do not lengthen or restart that hold.
- R7: If `sc_flag_i` is high in the single enabled cycle after a hold ends, a new full hold starts at once. A lasting short gives `RETRY_CYCLES` cycles off, then 1 cycle on, repeating.
- R8: `sc_sts_o` becomes 1 on the edge after `sc_flag_i` is high. It stays 1 until an edge with `clr_we_i`=1 and `clr_data_i[1]`=0, and a data bit of 1 leaves it unchanged. For both status bits, a set in the same cycle as a clear wins.
- R9: `fault_n_o` is 0 exactly when the undervoltage condition or a short hold is active, and `drv_en_o` always equals `fault_n_o`.
- R10: After reset, `fault_n_o`, `drv_en_o` and `cp_en_o` are 1 and `sc_sts_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag_i | input | 1 | Charge pump undervoltage flag, synchronous |
| sc_flag_i | input | 1 | Charge pump short-circuit flag, synchronous |
| clr_we_i | input | 1 | Status clear strobe |
| clr_data_i | input | 2 | Clear data; bit 0 is undervoltage, bit 1 is short; 0 clears |
| fault_n_o | output | 1 | Active-low fault indication |
| drv_en_o | output | 1 | Motor driver enable |
| cp_en_o | output | 1 | Charge pump enable |
| uv_sts_o | output | 1 | Sticky undervoltage status |
| sc_sts_o | output | 1 | Sticky short-circuit status |

## Verification
Undervoltage is tried with a one-cycle pulse and with a long level. These tell level-following recovery apart from any hidden timer.

A single short pulse measures the exact hold length. A second pulse inside a hold shows whether the timer is wrongly restarted. A lasting short exposes the off/on retry period and the one-cycle gap between holds. Overlapping undervoltage and short holds, together with clear writes that carry 1s or coincide with a new event, separate the per-condition fault merging and the set-over-clear priority.

// File: rtl/cpfs_pkg.sv
package cpfs_pkg;
    // Status bit positions in the clear data word
    localparam int unsigned STS_UV = 0;
    localparam int unsigned STS_SC = 1;
    localparam int unsigned N_STS  = 2;

    typedef enum logic {
        SC_RUN  = 1'b0,
        SC_HOLD = 1'b1
    } sc_state_e;
endpackage

// File: rtl/cpfs_sticky.sv
module cpfs_sticky #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic sts_o
);
    typedef struct packed {
        logic sts;
    } st_t;

    st_t st_d, st_q;

    // A new event overrides a clear in the same cycle
    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.sts = 1'b1;
        end else if (clr_i) begin
            st_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sts <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;
endmodule

// File: rtl/cpfs_retry_timer.sv
module cpfs_retry_timer
    import cpfs_pkg::*;
#(
    parameter int unsigned RETRY_CYCLES = 1_000_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic short_i,
    output logic hold_o
);
    localparam int unsigned CW = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RETRY_CYCLES - 1);

    typedef struct packed {
        sc_state_e       state;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            SC_RUN: begin
                if (short_i) begin
                    st_d.state = SC_HOLD;
                    st_d.cnt   = LOAD;
                end
            end
            SC_HOLD: begin
                // Pump is off: flags seen during the hold are not acted on
                if (st_q.cnt == '0) begin
                    st_d.state = SC_RUN;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.state = SC_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= SC_RUN;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = (st_q.state == SC_HOLD);
endmodule

// File: rtl/cp_fault_supervisor.sv
module cp_fault_supervisor
    import cpfs_pkg::*;
#(
    parameter int unsigned RETRY_CYCLES = 1_000_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_flag_i,
    input  logic       sc_flag_i,
    input  logic       clr_we_i,
    input  logic [1:0] clr_data_i,
    output logic       fault_n_o,
    output logic       drv_en_o,
    output logic       cp_en_o,
    output logic       uv_sts_o,
    output logic       sc_sts_o
);
    typedef struct packed {
        logic uv_act;
    } st_t;

    st_t st_d, st_q;

    logic             sc_hold;
    logic [N_STS-1:0] sts_set;
    logic [N_STS-1:0] sts_clr;
    logic [N_STS-1:0] sts_val;

    // Undervoltage follows its flag level, one register stage
    always_comb begin
        st_d        = st_q;
        st_d.uv_act = uv_flag_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.uv_act <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    cpfs_retry_timer #(
        .RETRY_CYCLES(RETRY_CYCLES)
    ) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .short_i(sc_flag_i),
        .hold_o (sc_hold)
    );

    always_comb begin
        sts_set         = '0;
        sts_set[STS_UV] = uv_flag_i;
        sts_set[STS_SC] = sc_flag_i;
        sts_clr         = {N_STS{clr_we_i}} & ~clr_data_i;
    end

    for (genvar i = 0; i < N_STS; i++) begin : g_sts
        cpfs_sticky #(
            .RESET_VAL((i == STS_UV) ? 1'b1 : 1'b0)
        ) u_sts (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(sts_set[i]),
            .clr_i(sts_clr[i]),
            .sts_o(sts_val[i])
        );
    end

    assign fault_n_o = ~(st_q.uv_act | sc_hold);
    assign drv_en_o  = ~(st_q.uv_act | sc_hold);
    assign cp_en_o   = ~sc_hold;
    assign uv_sts_o  = sts_val[STS_UV];
    assign sc_sts_o  = sts_val[STS_SC];
endmodule

// File: rtl/cpfs_checker.sv
module cpfs_checker #(
    parameter int unsigned RETRY_CYCLES = 1_000_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       uv_flag_i,
    input logic       sc_flag_i,
    input logic       clr_we_i,
    input logic [1:0] clr_data_i,
    input logic       fault_n_o,
    input logic       drv_en_o,
    input logic       cp_en_o,
    input logic       uv_sts_o,
    input logic       sc_sts_o
);
    // Length of the current pump-off run, counted in the checker
    logic [31:0] off_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cnt <= '0;
        end else if (cp_en_o) begin
            off_cnt <= '0;
        end else begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    p_uv_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag_i |=> (!drv_en_o && !fault_n_o));

    p_uv_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_flag_i |=> (drv_en_o == cp_en_o));

    p_uv_sts_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag_i |=> uv_sts_o);

    p_uv_sts_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_sts_o && !(clr_we_i && !clr_data_i[0])) |=> uv_sts_o);

    p_sc_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_flag_i && cp_en_o) |=> (!cp_en_o && !drv_en_o && !fault_n_o));

    p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_en_o) |-> (off_cnt == RETRY_CYCLES));

    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        off_cnt <= RETRY_CYCLES);

    p_sc_sts_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_flag_i |=> sc_sts_o);

    p_sc_sts_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_sts_o && !(clr_we_i && !clr_data_i[1])) |=> sc_sts_o);

    p_fault_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n_o == drv_en_o) && (cp_en_o || !fault_n_o));
endmodule

bind cp_fault_supervisor cpfs_checker #(
    .RETRY_CYCLES(RETRY_CYCLES)
) u_cpfs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_flag_i (uv_flag_i),
    .sc_flag_i (sc_flag_i),
    .clr_we_i  (clr_we_i),
    .clr_data_i(clr_data_i),
    .fault_n_o (fault_n_o),
    .drv_en_o  (drv_en_o),
    .cp_en_o   (cp_en_o),
    .uv_sts_o  (uv_sts_o),
    .sc_sts_o  (sc_sts_o)
);

// File: tb/test_cp_fault_supervisor.sv
`timescale 1ns/1ps
module test_cp_fault_supervisor;
    localparam int unsigned RETRY = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv_flag_i = 1'b0;
    logic       sc_flag_i = 1'b0;
    logic       clr_we_i = 1'b0;
    logic [1:0] clr_data_i = 2'b11;
    logic       fault_n_o, drv_en_o, cp_en_o, uv_sts_o, sc_sts_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cp_fault_supervisor #(.RETRY_CYCLES(RETRY)) i_cp_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .uv_flag_i(uv_flag_i), .sc_flag_i(sc_flag_i),
        .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .fault_n_o(fault_n_o),
        .drv_en_o(drv_en_o), .cp_en_o(cp_en_o), .uv_sts_o(uv_sts_o), .sc_sts_o(sc_sts_o)
    );

    // Behavioural reference model
    int m_uv_act, m_hold, m_left, m_uv_sts, m_sc_sts;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_uv_act = 0; m_hold = 0; m_left = 0; m_uv_sts = 1; m_sc_sts = 0;
        end else begin
            m_uv_act = uv_flag_i;
            if (m_hold != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) m_hold = 0;
            end else if (sc_flag_i) begin
                m_hold = 1;
                m_left = RETRY;
            end
            if (uv_flag_i) m_uv_sts = 1;
            else if (clr_we_i && !clr_data_i[0]) m_uv_sts = 0;
            if (sc_flag_i) m_sc_sts = 1;
            else if (clr_we_i && !clr_data_i[1]) m_sc_sts = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 fault_n vs model", fault_n_o, !(m_uv_act || m_hold));
            chk("R1 drv_en vs model", drv_en_o, !(m_uv_act || m_hold));
            chk("R5 cp_en vs model", cp_en_o, !m_hold);
            chk("R4 uv_sts vs model", uv_sts_o, m_uv_sts);
            chk("R8 sc_sts vs model", sc_sts_o, m_sc_sts);
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] d);
        clr_we_i = 1'b1; clr_data_i = d;
        step();
        clr_we_i = 1'b0; clr_data_i = 2'b11;
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (cp_en_o == lvl && n < 1000) begin
            n++;
            step();
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        step(3);
        rst_n = 1'b1;
        step();
        // R10 / R3 reset state
        chk("R10 fault_n after reset", fault_n_o, 1);
        chk("R10 drv_en after reset", drv_en_o, 1);
        chk("R10 cp_en after reset", cp_en_o, 1);
        chk("R10 sc_sts after reset", sc_sts_o, 0);
        chk("R3 uv_sts after reset", uv_sts_o, 1);

        // R4 clear uv only (bit0=0), bit1=1 no effect
        wr(2'b10);
        chk("R4 uv_sts cleared by 0", uv_sts_o, 0);

        // R1/R2 one-cycle undervoltage pulse
        uv_flag_i = 1'b1; step(); uv_flag_i = 1'b0;
        chk("R1 drv_en low on uv", drv_en_o, 0);
        chk("R1 fault_n low on uv", fault_n_o, 0);
        chk("R1 cp_en unaffected by uv", cp_en_o, 1);
        step();
        chk("R2 drv_en back without timer", drv_en_o, 1);
        chk("R4 uv_sts set by event", uv_sts_o, 1);
        wr(2'b01);
        chk("R4 write of 1 keeps uv_sts", uv_sts_o, 1);

        // R1/R2 long undervoltage level
        uv_flag_i = 1'b1; step(20);
        chk("R1 drv_en low during long uv", drv_en_o, 0);
        uv_flag_i = 1'b0; step();
        chk("R2 drv_en back after long uv", drv_en_o, 1);
        wr(2'b00);
        chk("R4 uv_sts cleared", uv_sts_o, 0);

        // R5 single short pulse: hold length
        sc_flag_i = 1'b1; step(); sc_flag_i = 1'b0;
        count_level(1'b0, n);
        chk("R5 hold length", n, RETRY);
        chk("R8 sc_sts set", sc_sts_o, 1);
        wr(2'b10);
        chk("R8 write of 1 keeps sc_sts", sc_sts_o, 1);
        wr(2'b01);
        chk("R8 sc_sts cleared by 0", sc_sts_o, 0);

        // R6 flag during hold does not restart
        sc_flag_i = 1'b1; step(); sc_flag_i = 1'b0;
        step(3);
        sc_flag_i = 1'b1; step(); sc_flag_i = 1'b0;
        n = 4;
        begin
            int rest;
            count_level(1'b0, rest);
            n = n + rest;
        end
        chk("R6 hold length unchanged", n, RETRY);
        step(2);

        // R7 persistent short
        sc_flag_i = 1'b1; step();
        count_level(1'b0, n);
        chk("R7 first hold", n, RETRY);
        count_level(1'b1, n);
        chk("R7 one enabled cycle", n, 1);
        count_level(1'b0, n);
        chk("R7 second hold", n, RETRY);
        sc_flag_i = 1'b0;
        step(RETRY + 2);

        // R8 set wins over clear in same cycle
        sc_flag_i = 1'b1; uv_flag_i = 1'b1; clr_we_i = 1'b1; clr_data_i = 2'b00;
        step();
        sc_flag_i = 1'b0; clr_we_i = 1'b0; clr_data_i = 2'b11;
        chk("R8 set beats clear sc", sc_sts_o, 1);
        chk("R8 set beats clear uv", uv_sts_o, 1);

        // R9 overlap: uv drops during short hold
        step(2);
        uv_flag_i = 1'b0; step();
        chk("R9 drv_en held by short", drv_en_o, 0);
        chk("R9 fault_n held by short", fault_n_o, 0);
        count_level(1'b0, n);
        chk("R9 fault released after hold", fault_n_o, 1);
        step(4);
        finish_run();
    end
endmodule